// File: doc/BRIEF.md
# Register-Map Address Decoder with External Regions

This block is the address-decode stage of a memory-mapped register block. It is purely combinational. It takes a request-valid bit that an upstream CPU interface stage has already masked and a byte address relative to the base of the register map. From these it raises at most one access strobe. The strobe goes to a plain register, to one access-width slice of a wide register, to one element of a two-dimensional register array, or to an externally implemented region that is forwarded as a single address window.

An is_external flag tells the next stage to pass the access on instead of servicing it locally. It is set for any hit in the external window and for any slice of a register that is marked as implemented outside the block. The layout of the map is given as absolute addresses plus the absolute base of the map, and the decoder subtracts that base itself.

The block has no clock. All of its control pins are plain levels, so there is no back-pressure. A request that reaches the decoder is decoded in the same cycle, and the stage that registers the result owns any flow control.

Top module: `regmap_addr_decode`

## Requirements
- R1: With req_masked high, strb_ctrl is high exactly when addr equals the control register's absolute address minus the map base (0x000 with defaults). strb_stat is high exactly when addr equals the status register's offset (0x004).
- R2: The 64-bit register with a 32-bit access width has two slice strobes. Bit i of strb_wide is high exactly when addr equals its offset (0x008) plus 4·i, so bit 0 is at 0x008 and bit 1 is at 0x00C.
- R3: Array element (i0, i1) drives strb_arr bit i0·2+i1. Its address is the array offset (0x010) plus i1 times the element stride (8) plus i0 times the outer stride. The outer stride is the element stride times the inner dimension size (2), which gives 16. The elements sit at 0x010, 0x018, 0x020 and 0x028.
- R4: strb_ext is high for every address from the window offset (0x100) up to the offset plus size minus one (0x1FF), both ends included. It is low at 0x0FF and at 0x200.
- R5: An address inside the external window raises only strb_ext and is_external, and no register strobe.
- R6: is_external is high exactly when strb_ext is high or when either slice strobe of the wide register is high, because that register is marked external by default.
- R7: While req_masked is low, every strobe and is_external are low, whatever the address.
- R8: An address that matches no register and no window, including gaps between array elements and unaligned addresses, raises no strobe and leaves is_external low.
- R9: At most one strobe is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_masked | input | 1 | Request valid, already masked upstream |
| addr | input | ADDR_W (12) | Byte address relative to the map base |
| strb_ctrl | output | 1 | Control register strobe |
| strb_stat | output | 1 | Status register strobe |
| strb_wide | output | WIDE_W/ACCESS_W (2) | One strobe per access-width slice of the wide register |
| strb_arr | output | ARR_DIM0·ARR_DIM1 (4) | One strobe per array element, index i0·ARR_DIM1+i1 |
| strb_ext | output | 1 | External window strobe |
| is_external | output | 1 | Access must be forwarded outside the block |

## Verification
The bench probes both edges of the external window and the addresses just outside it. A decoder with an off-by-one limit or an exclusive upper bound would lose 0x1FF or take 0x0FF or 0x200. The array elements are checked at addresses where a swapped stride order or an unmultiplied outer stride would light the wrong bit, and the gap addresses between elements are checked as well. The bench sweeps the whole address space, counts the decoded addresses and the addresses flagged external, and looks for overlaps. A stray match from a truncated offset, a second slice at the wrong step, a missing external term or a strobe that leaks while the request is low therefore shows up as a wrong count.

// File: rtl/regdec_pkg.sv
package regdec_pkg;

  // Stride of an outer array dimension from the next inner one
  function automatic int unsigned outer_stride(int unsigned inner_stride,
                                               int unsigned inner_dim);
    return inner_stride * inner_dim;
  endfunction

  // Byte step between slices of a wide register
  function automatic int unsigned slice_bytes(int unsigned access_w);
    return access_w / 8;
  endfunction

  // Flattened strobe index of a two-dimensional element
  function automatic int unsigned flat_index(int unsigned i0, int unsigned i1,
                                             int unsigned dim1);
    return i0 * dim1 + i1;
  endfunction

endpackage

// File: rtl/regdec_word_match.sv
module regdec_word_match #(
  parameter int unsigned         ADDR_W = 12,
  parameter logic [ADDR_W-1:0]   OFFSET = '0
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  always_comb begin
    hit = 1'b0;
    if (req && (addr == OFFSET)) hit = 1'b1;
  end

  // A hit may only appear while a request is present
  always_comb begin
    if (!$isunknown({req, addr}) && hit) begin
      assert_hit_needs_req_R7: assert (req)
        else $error("word hit without request");
    end
  end

endmodule

// File: rtl/regdec_wide_match.sv
module regdec_wide_match
  import regdec_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OFFSET   = '0,
  parameter int unsigned       REG_W    = 64,
  parameter int unsigned       ACCESS_W = 32,
  parameter bit                IS_EXT   = 1'b0,
  localparam int unsigned      NSUB     = REG_W / ACCESS_W
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic [NSUB-1:0]   strb,
  output logic [NSUB-1:0]   ext_terms
);

  localparam int unsigned STEP = slice_bytes(ACCESS_W);
  localparam int unsigned SPAN = NSUB * STEP;

  for (genvar g = 0; g < NSUB; g++) begin : g_slice
    regdec_word_match #(
      .ADDR_W (ADDR_W),
      .OFFSET (OFFSET + ADDR_W'(g * STEP))
    ) u_slice (
      .req  (req),
      .addr (addr),
      .hit  (strb[g])
    );
  end

  if (IS_EXT) begin : g_ext
    assign ext_terms = strb;
  end else begin : g_int
    assign ext_terms = '0;
  end

  // Slices never overlap, and any slice hit lies inside the register span
  always_comb begin
    if (!$isunknown({req, addr})) begin
      assert_slice_onehot_R2: assert ($onehot0(strb))
        else $error("two slices of one register hit");
      if (strb != '0) begin
        assert_slice_in_span_R2: assert ((32'(addr) - 32'(OFFSET)) < SPAN)
          else $error("slice hit outside register span");
      end
    end
  end

endmodule

// File: rtl/regdec_array_match.sv
module regdec_array_match
  import regdec_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] BASE_OFF    = '0,
  parameter int unsigned       DIM0        = 2,
  parameter int unsigned       DIM1        = 2,
  parameter int unsigned       ELEM_STRIDE = 8,
  localparam int unsigned      NELEM       = DIM0 * DIM1
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic [NELEM-1:0]  strb
);

  localparam int unsigned STRIDE1 = ELEM_STRIDE;
  localparam int unsigned STRIDE0 = outer_stride(STRIDE1, DIM1);
  localparam int unsigned SPAN    = DIM0 * STRIDE0;

  for (genvar i0 = 0; i0 < DIM0; i0++) begin : g_outer
    for (genvar i1 = 0; i1 < DIM1; i1++) begin : g_inner
      regdec_word_match #(
        .ADDR_W (ADDR_W),
        .OFFSET (BASE_OFF + ADDR_W'(i0 * STRIDE0 + i1 * STRIDE1))
      ) u_elem (
        .req  (req),
        .addr (addr),
        .hit  (strb[flat_index(i0, i1, DIM1)])
      );
    end
  end

  // An element hit lands on a stride boundary inside the array span
  always_comb begin
    if (!$isunknown({req, addr}) && (strb != '0)) begin
      assert_elem_on_stride_R3: assert ((((32'(addr) - 32'(BASE_OFF)) % STRIDE1) == 0)
                                        && ((32'(addr) - 32'(BASE_OFF)) < SPAN))
        else $error("array hit off the element grid");
      assert_elem_onehot_R3: assert ($onehot0(strb))
        else $error("two array elements hit");
    end
  end

endmodule

// File: rtl/regdec_range_match.sv
module regdec_range_match #(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] BASE_OFF = '0,
  parameter int unsigned       SIZE     = 256
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [ADDR_W:0] LO = {1'b0, BASE_OFF};
  localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(SIZE - 1);

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr};

  always_comb begin
    hit = 1'b0;
    if (req && (addr_x >= LO) && (addr_x <= HI)) hit = 1'b1;
  end

  // A window hit means the distance from the base is below the size
  always_comb begin
    if (!$isunknown({req, addr}) && hit) begin
      assert_window_bounds_R4: assert ((32'(addr) - 32'(BASE_OFF)) < SIZE)
        else $error("window hit outside its range");
    end
  end

endmodule

// File: rtl/regmap_addr_decode.sv
module regmap_addr_decode
  import regdec_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned ACCESS_W      = 32,
  parameter int unsigned MAP_BASE      = 32'h0000_2000,
  parameter int unsigned CTRL_ABS      = 32'h0000_2000,
  parameter int unsigned STAT_ABS      = 32'h0000_2004,
  parameter int unsigned WIDE_ABS      = 32'h0000_2008,
  parameter int unsigned WIDE_W        = 64,
  parameter bit          WIDE_EXTERNAL = 1'b1,
  parameter int unsigned ARR_ABS       = 32'h0000_2010,
  parameter int unsigned ARR_DIM0      = 2,
  parameter int unsigned ARR_DIM1      = 2,
  parameter int unsigned ARR_STRIDE    = 8,
  parameter int unsigned EXT_ABS       = 32'h0000_2100,
  parameter int unsigned EXT_SIZE      = 32'h0000_0100
) (
  input  logic                            req_masked,
  input  logic [ADDR_W-1:0]               addr,
  output logic                            strb_ctrl,
  output logic                            strb_stat,
  output logic [WIDE_W/ACCESS_W-1:0]      strb_wide,
  output logic [ARR_DIM0*ARR_DIM1-1:0]    strb_arr,
  output logic                            strb_ext,
  output logic                            is_external
);

  localparam int unsigned WIDE_SUBS = WIDE_W / ACCESS_W;
  localparam int unsigned ARR_N     = ARR_DIM0 * ARR_DIM1;
  localparam int unsigned ALL_N     = 2 + WIDE_SUBS + ARR_N + 1;

  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(CTRL_ABS - MAP_BASE);
  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(STAT_ABS - MAP_BASE);
  localparam logic [ADDR_W-1:0] WIDE_OFF = ADDR_W'(WIDE_ABS - MAP_BASE);
  localparam logic [ADDR_W-1:0] ARR_OFF  = ADDR_W'(ARR_ABS  - MAP_BASE);
  localparam logic [ADDR_W-1:0] EXT_OFF  = ADDR_W'(EXT_ABS  - MAP_BASE);

  logic [WIDE_SUBS-1:0] wide_ext_terms;

  regdec_word_match #(.ADDR_W(ADDR_W), .OFFSET(CTRL_OFF)) u_ctrl (
    .req (req_masked), .addr (addr), .hit (strb_ctrl)
  );

  regdec_word_match #(.ADDR_W(ADDR_W), .OFFSET(STAT_OFF)) u_stat (
    .req (req_masked), .addr (addr), .hit (strb_stat)
  );

  regdec_wide_match #(
    .ADDR_W   (ADDR_W),
    .OFFSET   (WIDE_OFF),
    .REG_W    (WIDE_W),
    .ACCESS_W (ACCESS_W),
    .IS_EXT   (WIDE_EXTERNAL)
  ) u_wide (
    .req       (req_masked),
    .addr      (addr),
    .strb      (strb_wide),
    .ext_terms (wide_ext_terms)
  );

  regdec_array_match #(
    .ADDR_W      (ADDR_W),
    .BASE_OFF    (ARR_OFF),
    .DIM0        (ARR_DIM0),
    .DIM1        (ARR_DIM1),
    .ELEM_STRIDE (ARR_STRIDE)
  ) u_arr (
    .req  (req_masked),
    .addr (addr),
    .strb (strb_arr)
  );

  regdec_range_match #(
    .ADDR_W   (ADDR_W),
    .BASE_OFF (EXT_OFF),
    .SIZE     (EXT_SIZE)
  ) u_ext (
    .req  (req_masked),
    .addr (addr),
    .hit  (strb_ext)
  );

  // Forward flag: window hit or any slice of a register kept outside
  always_comb begin
    is_external = 1'b0;
    is_external = is_external | strb_ext;
    is_external = is_external | (|wide_ext_terms);
  end

  logic [ALL_N-1:0] all_strb;
  assign all_strb = {strb_ctrl, strb_stat, strb_wide, strb_arr, strb_ext};

  always_comb begin
    if (!$isunknown({req_masked, addr})) begin
      assert_single_strobe_R9: assert ($onehot0(all_strb))
        else $error("more than one strobe high");
      if (!req_masked) begin
        assert_quiet_idle_R7: assert ((all_strb == '0) && !is_external)
          else $error("strobe without request");
      end
      if (strb_ext) begin
        assert_window_flags_ext_R6: assert (is_external)
          else $error("window hit not flagged external");
        assert_window_alone_R5: assert ((all_strb & ~ALL_N'(1)) == '0)
          else $error("register strobe inside window");
      end
    end
  end

endmodule

// File: tb/sim_regmap_addr_decode.sv
module sim_regmap_addr_decode;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_masked;
  logic [11:0] addr;
  logic        strb_ctrl, strb_stat, strb_ext, is_external;
  logic [1:0]  strb_wide;
  logic [3:0]  strb_arr;

  regmap_addr_decode u0 (
    .req_masked  (req_masked),
    .addr        (addr),
    .strb_ctrl   (strb_ctrl),
    .strb_stat   (strb_stat),
    .strb_wide   (strb_wide),
    .strb_arr    (strb_arr),
    .strb_ext    (strb_ext),
    .is_external (is_external)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // {req_no, req, addr, ctrl stat wide1 wide0 arr3 arr2 arr1 arr0 ext is_ext}
  localparam int NVEC = 20;
  localparam logic [26:0] VEC [NVEC] = '{
    {4'd1, 1'b1, 12'h000, 10'b10_00_0000_00},
    {4'd1, 1'b1, 12'h004, 10'b01_00_0000_00},
    {4'd2, 1'b1, 12'h008, 10'b00_01_0000_01},
    {4'd2, 1'b1, 12'h00C, 10'b00_10_0000_01},
    {4'd3, 1'b1, 12'h010, 10'b00_00_0001_00},
    {4'd3, 1'b1, 12'h018, 10'b00_00_0010_00},
    {4'd3, 1'b1, 12'h020, 10'b00_00_0100_00},
    {4'd3, 1'b1, 12'h028, 10'b00_00_1000_00},
    {4'd8, 1'b1, 12'h014, 10'b00_00_0000_00},
    {4'd8, 1'b1, 12'h002, 10'b00_00_0000_00},
    {4'd4, 1'b1, 12'h100, 10'b00_00_0000_11},
    {4'd4, 1'b1, 12'h1FF, 10'b00_00_0000_11},
    {4'd5, 1'b1, 12'h180, 10'b00_00_0000_11},
    {4'd4, 1'b1, 12'h0FF, 10'b00_00_0000_00},
    {4'd4, 1'b1, 12'h200, 10'b00_00_0000_00},
    {4'd7, 1'b0, 12'h000, 10'b00_00_0000_00},
    {4'd7, 1'b0, 12'h100, 10'b00_00_0000_00},
    {4'd7, 1'b0, 12'h008, 10'b00_00_0000_00},
    {4'd8, 1'b1, 12'hFFC, 10'b00_00_0000_00},
    {4'd8, 1'b1, 12'h030, 10'b00_00_0000_00}
  };

  function automatic string tag(int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R6";
      7: return "R7";  8: return "R8";  default: return "R9";
    endcase
  endfunction

  function automatic logic [9:0] observed();
    return {strb_ctrl, strb_stat, strb_wide, strb_arr, strb_ext, is_external};
  endfunction

  task automatic check(string rq, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", rq, what, got, exp);
    end
  endtask

  task automatic apply(logic r, logic [11:0] a);
    @(posedge clk);
    req_masked <= r;
    addr       <= a;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hits, ext_hits, multi;
    req_masked = 1'b0;
    addr       = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7 reset state: no request, nothing decoded
    check("R7", "reset state outputs", int'(observed()), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][22], VEC[k][21:10]);
      check(tag(int'(VEC[k][26:23])), $sformatf("vector %0d addr 0x%0h", k, VEC[k][21:10]),
            int'(observed()), int'(VEC[k][9:0]));
    end

    // Full sweep with request high: R4 window, R6 flag, R9 exclusivity
    hits = 0; ext_hits = 0; multi = 0;
    for (int a = 0; a < 4096; a++) begin
      apply(1'b1, 12'(a));
      if (observed()[9:1] != '0) hits++;
      if (is_external) ext_hits++;
      if (!$onehot0(observed()[9:1])) multi++;
      if (is_external != (strb_ext | strb_wide[0] | strb_wide[1])) multi++;
    end
    check("R8", "decoded address count", hits, 264);
    check("R6", "external address count", ext_hits, 258);
    check("R9", "overlapping strobes or bad flag", multi, 0);

    // Full sweep with request low: R7
    hits = 0;
    for (int a = 0; a < 4096; a++) begin
      apply(1'b0, 12'(a));
      if (observed() != '0) hits++;
    end
    check("R7", "activity while idle", hits, 0);

    // Directed: R2 second slice flags external, R3 last element only
    apply(1'b1, 12'h00C);
    check("R6", "wide slice 1 external flag", int'(is_external), 1);
    apply(1'b1, 12'h028);
    check("R3", "element (1,1) bit", int'(strb_arr), 8);
    check("R5", "no external flag on internal array", int'(is_external), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule